// File: doc/BRIEF.md
# Peak-Current PWM Gate Controller

This block produces the on/off command for the power switch of a current-mode converter. A `cycle_start` strobe turns the gate on. The pulse then ends on the first terminating event. The events are:

- a trip from the peak-current comparator, which compares sensed current with the lower of the two loop error signals;
- a trip from the fixed hard-limit comparator;
- reaching the longest on-time that the maximum duty ratio allows.

Once a pulse has ended, the gate stays low until the next `cycle_start`.

Both comparator outputs arrive as asynchronous levels. Each passes through a two-flop synchronizer inside the block. A blanking window right after turn-on discards comparator activity, which hides the turn-on spike. A minimum on-time holds the pulse on even after a trip. A trip noticed during that interval is remembered and ends the pulse as soon as the interval expires. A global `enable` overrides everything and pulls the gate low at the next clock.

The controller is a five-state machine:

- `ST_IDLE`: disabled, or never started.
- `ST_BLANK`: gate on, trips discarded.
- `ST_HOLD`: gate on, trips recorded as pending.
- `ST_ARMED`: gate on, trips act at once.
- `ST_DONE`: pulse ended, cause held.

The transitions are:

- start: `ST_IDLE`/`ST_DONE` to `ST_BLANK` on `cycle_start`.
- blank expiry: `ST_BLANK` to `ST_HOLD`. It goes straight to `ST_ARMED` when the minimum on-time is not longer than the blanking window.
- guard expiry: `ST_HOLD` to `ST_ARMED` when no trip is pending, or to `ST_DONE` when one is.
- terminate: `ST_ARMED` to `ST_DONE` on a trip or at the duty limit.
- abort: any state to `ST_IDLE` when `enable` is low.

Top module: `pcm_gate_ctrl`

## Requirements
- R1: After reset, `gate` is 0 and `term_cause` is 0.
- R2: With `enable` high and no pulse in progress, a `cycle_start` sampled at a clock edge sets `gate` to 1 right after that edge and clears `term_cause` to 0.
- R3: Each comparator input reaches the state machine through two flops. A level applied before clock edge k is acted on at edge k+2, so once the pulse is armed the gate falls right after that edge.
- R4: A peak-comparator trip acted on in `ST_ARMED` ends the pulse and sets `term_cause` to 1.
- R5: A hard-limit trip ends the pulse and sets `term_cause` to 2. If both comparators trip in the same cycle, the hard limit wins with code 2.
- R6: Comparator trips seen by the state machine during the first BLANK_CYC clock edges of a pulse (default 30) are discarded and have no effect on the pulse.
- R7: The gate stays on for at least MIN_ON_CYC cycles (default 80). A trip seen after blanking but before that point ends the pulse exactly at MIN_ON_CYC cycles, with the cause of that trip.
- R8: Without trips, the gate stays on for exactly PERIOD_CYC*DUTY_PCT/100 cycles (default 1300) and `term_cause` becomes 3.
- R9: After a pulse ends, `gate` stays 0 and `term_cause` keeps its code until the next `cycle_start`, even after the comparator inputs return low.
- R10: With `enable` sampled low at an edge, `gate` is 0 after that edge, even inside the minimum on-time, and `term_cause` is cleared to 0. While `enable` is low, `cycle_start` is ignored.
- R11: A `cycle_start` arriving while the gate is on is ignored, and the pulse length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable. Low forces the gate off and aborts the cycle |
| cycle_start | input | 1 | One-clock strobe that opens a switching cycle |
| peak_cmp_a | input | 1 | Asynchronous peak-current comparator output, high = trip |
| ilim_cmp_a | input | 1 | Asynchronous hard current-limit comparator output, high = trip |
| gate | output | 1 | Power-switch gate command |
| term_cause | output | 2 | Why the last pulse ended: 0 none/aborted, 1 peak, 2 hard limit, 3 duty limit |

## Verification
The assertions assume `cycle_start` and `enable` are synchronous to `clk`. They also assume `cycle_start` is not issued so often that the duty limit would exceed the period. The bench drives every input only on falling clock edges. It leaves at least a few idle cycles between pulses, so the synchronizer is flushed before the next blanking window opens. Comparator pulses are held for whole clock cycles. Their placement is chosen from the three-edge synchronizer latency, so that each one lands on a known state boundary.

// File: rtl/pcm_gate_pkg.sv
package pcm_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BLANK = 3'd1,
        ST_HOLD  = 3'd2,
        ST_ARMED = 3'd3,
        ST_DONE  = 3'd4
    } gate_state_e;

    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_PEAK = 2'd1,
        END_HARD = 2'd2,
        END_DUTY = 2'd3
    } end_cause_e;

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/pcm_on_timer.sv
module pcm_on_timer #(
    parameter int CNT_W      = 11,
    parameter int BLANK_CYC  = 30,
    parameter int GUARD_CYC  = 80,
    parameter int MAX_ON_CYC = 1300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] on_cnt,
    output logic             blank_end,
    output logic             guard_end,
    output logic             duty_end
);

    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_CYC - 1);
    localparam logic [CNT_W-1:0] DUTY_LAST  = CNT_W'(MAX_ON_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_TOP    = CNT_W'(MAX_ON_CYC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                on_cnt <= '0;
        else if (!run)             on_cnt <= '0;
        else if (on_cnt != CNT_TOP) on_cnt <= on_cnt + 1'b1;
    end

    always_comb begin
        blank_end = run && (on_cnt == BLANK_LAST);
        guard_end = run && (on_cnt == GUARD_LAST);
        duty_end  = run && (on_cnt == DUTY_LAST);
    end

    // R8
    on_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (on_cnt < CNT_TOP));

endmodule

// File: rtl/pcm_gate_fsm.sv
module pcm_gate_fsm
    import pcm_gate_pkg::*;
#(
    parameter int BLANK_CYC = 30,
    parameter int GUARD_CYC = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       cycle_start,
    input  logic       peak_s,
    input  logic       hard_s,
    input  logic       blank_end,
    input  logic       guard_end,
    input  logic       duty_end,
    output logic       gate,
    output logic [1:0] cause
);

    localparam bit HAS_HOLD = (GUARD_CYC > BLANK_CYC);

    gate_state_e st_q, st_d;
    end_cause_e  cause_q, cause_d;
    logic        pend_peak_q, pend_peak_d;
    logic        pend_hard_q, pend_hard_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cause_q     <= END_NONE;
            pend_peak_q <= 1'b0;
            pend_hard_q <= 1'b0;
        end else begin
            st_q        <= st_d;
            cause_q     <= cause_d;
            pend_peak_q <= pend_peak_d;
            pend_hard_q <= pend_hard_d;
        end
    end

    always_comb begin
        st_d        = st_q;
        cause_d     = cause_q;
        pend_peak_d = pend_peak_q;
        pend_hard_d = pend_hard_q;
        if (!enable) begin
            st_d        = ST_IDLE;
            cause_d     = END_NONE;
            pend_peak_d = 1'b0;
            pend_hard_d = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (cycle_start) begin
                        st_d        = ST_BLANK;
                        cause_d     = END_NONE;
                        pend_peak_d = 1'b0;
                        pend_hard_d = 1'b0;
                    end
                end
                ST_BLANK: begin
                    if (blank_end) st_d = HAS_HOLD ? ST_HOLD : ST_ARMED;
                end
                ST_HOLD: begin
                    pend_peak_d = pend_peak_q | peak_s;
                    pend_hard_d = pend_hard_q | hard_s;
                    if (guard_end) begin
                        if (pend_hard_d) begin
                            st_d    = ST_DONE;
                            cause_d = END_HARD;
                        end else if (pend_peak_d) begin
                            st_d    = ST_DONE;
                            cause_d = END_PEAK;
                        end else begin
                            st_d = ST_ARMED;
                        end
                    end
                end
                ST_ARMED: begin
                    if (hard_s) begin
                        st_d    = ST_DONE;
                        cause_d = END_HARD;
                    end else if (peak_s) begin
                        st_d    = ST_DONE;
                        cause_d = END_PEAK;
                    end else if (duty_end) begin
                        st_d    = ST_DONE;
                        cause_d = END_DUTY;
                    end
                end
                default: begin
                    st_d    = ST_IDLE;
                    cause_d = END_NONE;
                end
            endcase
        end
    end

    always_comb begin
        gate  = (st_q == ST_BLANK) || (st_q == ST_HOLD) || (st_q == ST_ARMED);
        cause = cause_q;
    end

    // R10
    gate_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate);

    // R2
    gate_rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> ($past(cycle_start) && cause == END_NONE));

    // R4
    end_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate) && $past(enable)) |-> (cause != END_NONE));

    // R9
    done_cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && $past(st_q) == ST_DONE) |-> ($stable(cause) && !gate));

endmodule

// File: rtl/pcm_gate_ctrl.sv
module pcm_gate_ctrl #(
    parameter int PERIOD_CYC  = 2000,
    parameter int DUTY_PCT    = 65,
    parameter int BLANK_CYC   = 30,
    parameter int MIN_ON_CYC  = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       cycle_start,
    input  logic       peak_cmp_a,
    input  logic       ilim_cmp_a,
    output logic       gate,
    output logic [1:0] term_cause
);

    localparam int MAX_ON_CYC = (PERIOD_CYC * DUTY_PCT) / 100;
    localparam int GUARD_CYC  = (MIN_ON_CYC > BLANK_CYC) ? MIN_ON_CYC : BLANK_CYC;
    localparam int CNT_W      = $clog2(MAX_ON_CYC + 1);

    logic [1:0]       cmp_sync;
    logic [CNT_W-1:0] on_cnt;
    logic             blank_end, guard_end, duty_end;

    pcm_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ilim_cmp_a, peak_cmp_a}),
        .d_sync  (cmp_sync)
    );

    pcm_on_timer #(
        .CNT_W      (CNT_W),
        .BLANK_CYC  (BLANK_CYC),
        .GUARD_CYC  (GUARD_CYC),
        .MAX_ON_CYC (MAX_ON_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (gate),
        .on_cnt    (on_cnt),
        .blank_end (blank_end),
        .guard_end (guard_end),
        .duty_end  (duty_end)
    );

    pcm_gate_fsm #(
        .BLANK_CYC (BLANK_CYC),
        .GUARD_CYC (GUARD_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cycle_start (cycle_start),
        .peak_s      (cmp_sync[0]),
        .hard_s      (cmp_sync[1]),
        .blank_end   (blank_end),
        .guard_end   (guard_end),
        .duty_end    (duty_end),
        .gate        (gate),
        .cause       (term_cause)
    );

    // R7
    min_on_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate) && $past(enable)) |-> ($past(on_cnt) >= CNT_W'(GUARD_CYC - 1)));

endmodule

// File: tb/sim_pcm_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pcm_gate_ctrl;

    localparam int MAX_ON = 1300;
    localparam int MIN_ON = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cycle_start = 1'b0;
    logic       peak_cmp_a = 1'b0;
    logic       ilim_cmp_a = 1'b0;
    logic       gate;
    logic [1:0] term_cause;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_len  = 0;
    int last_w   = 0;

    always #5 clk = ~clk;

    pcm_gate_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cycle_start (cycle_start),
        .peak_cmp_a  (peak_cmp_a),
        .ilim_cmp_a  (ilim_cmp_a),
        .gate        (gate),
        .term_cause  (term_cause)
    );

    always @(negedge clk) begin
        if (gate === 1'b1) cur_len = cur_len + 1;
        else if (cur_len != 0) begin
            last_w  = cur_len;
            cur_len = 0;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Opens a cycle; returns at the first falling edge after the start edge.
    task automatic fire();
        @(negedge clk);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
    endtask

    task automatic wait_low();
        for (int i = 0; i < 5000 && gate === 1'b1; i++) @(negedge clk);
        #1;
    endtask

    // Trip raised at falling edge k after the start; len 0 = hold until gate falls.
    task automatic trip_pulse(input int k, input int len, input bit pk, input bit hd,
                              output int width);
        fire();
        repeat (k - 1) @(negedge clk);
        peak_cmp_a = pk;
        ilim_cmp_a = hd;
        if (len > 0) begin
            repeat (len) @(negedge clk);
            peak_cmp_a = 1'b0;
            ilim_cmp_a = 1'b0;
        end
        wait_low();
        peak_cmp_a = 1'b0;
        ilim_cmp_a = 1'b0;
        width = last_w;
        idle(6);
    endtask

    task automatic t_reset();
        check("R1 gate after reset", int'(gate), 0);
        check("R1 cause after reset", int'(term_cause), 0);
    endtask

    task automatic t_max_duty();
        int w;
        fire();
        check("R2 gate high after start", int'(gate), 1);
        check("R2 cause cleared at start", int'(term_cause), 0);
        wait_low();
        w = last_w;
        check("R8 duty-limited width", w, MAX_ON);
        check("R8 duty cause", int'(term_cause), 3);
        idle(4);
    endtask

    task automatic t_peak_armed();
        int w;
        trip_pulse(200, 0, 1'b1, 1'b0, w);
        check("R3 R4 peak trip width", w, 202);
        check("R4 peak cause", int'(term_cause), 1);
    endtask

    task automatic t_hold_off();
        idle(20);
        check("R9 gate stays low after trip", int'(gate), 0);
        check("R9 cause held", int'(term_cause), 1);
        fire();
        check("R9 new cycle reopens gate", int'(gate), 1);
        check("R2 cause cleared on new cycle", int'(term_cause), 0);
        wait_low();
        idle(4);
    endtask

    task automatic t_hard_priority();
        int w;
        trip_pulse(150, 0, 1'b0, 1'b1, w);
        check("R5 hard trip width", w, 152);
        check("R5 hard cause", int'(term_cause), 2);
        trip_pulse(300, 0, 1'b1, 1'b1, w);
        check("R5 simultaneous width", w, 302);
        check("R5 hard wins over peak", int'(term_cause), 2);
    endtask

    task automatic t_blank();
        int w;
        trip_pulse(1, 3, 1'b1, 1'b1, w);
        check("R6 early trip discarded width", w, MAX_ON);
        check("R6 early trip discarded cause", int'(term_cause), 3);
        trip_pulse(28, 1, 1'b0, 1'b1, w);
        check("R6 trip on last blank edge discarded", w, MAX_ON);
        trip_pulse(29, 1, 1'b0, 1'b1, w);
        check("R7 trip just after blank deferred", w, MIN_ON);
        check("R7 deferred cause hard", int'(term_cause), 2);
    endtask

    task automatic t_min_on();
        int w;
        trip_pulse(40, 3, 1'b1, 1'b0, w);
        check("R7 mid-hold peak deferred", w, MIN_ON);
        check("R7 deferred cause peak", int'(term_cause), 1);
        trip_pulse(78, 0, 1'b1, 1'b0, w);
        check("R7 trip on guard edge", w, MIN_ON);
        trip_pulse(79, 0, 1'b1, 1'b0, w);
        check("R3 first armed trip", w, MIN_ON + 1);
    endtask

    task automatic t_disable();
        fire();
        repeat (99) @(negedge clk);
        enable = 1'b0;
        wait_low();
        check("R10 disable mid pulse width", last_w, 100);
        check("R10 cause cleared", int'(term_cause), 0);
        enable = 1'b1;
        idle(4);
        fire();
        repeat (9) @(negedge clk);
        enable = 1'b0;
        wait_low();
        check("R10 disable overrides min on-time", last_w, 10);
        fire();
        idle(2);
        check("R10 start ignored while disabled", int'(gate), 0);
        enable = 1'b1;
        idle(4);
    endtask

    task automatic t_restart_ignored();
        fire();
        repeat (4) @(negedge clk);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        wait_low();
        check("R11 start during pulse ignored", last_w, MAX_ON);
        idle(4);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        enable = 1'b1;
        idle(2);
        t_max_duty();
        t_peak_armed();
        t_hold_off();
        t_hard_priority();
        t_blank();
        t_min_on();
        t_disable();
        t_restart_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule